// File: doc/BRIEF.md
# Core Sleep and Wakeup Controller

This block decides when a processor core leaves the active state for a low-power state and when it comes back. Three requests ask for sleep: a wait-for-interrupt strobe, a wait-for-event strobe, and the return to thread code when the last handler finishes with sleep-on-exit enabled. A request is taken only when no interrupt is pending. A configuration bit picks a light sleep, where only the clock is gated, or a deep sleep, where a power-down request is also raised.

Three things end a sleep: a pending interrupt, a debug request, or an external event. The external event counts only in a light sleep that was entered through the wait-for-event strobe. A one-bit event latch records events that arrive while they cannot wake the core. A later wait-for-event uses up the latch and returns at once. On wakeup the clock enable comes back, and a one-cycle wake pulse is raised in that same cycle.

In deep sleep, wake detection models a small always-on controller. It watches only the retained interrupt-pending line and the debug request.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: In the active state, a wait-for-interrupt or wait-for-event strobe starts a sleep on the next clock edge only if `irq_pending_i` is low. If it is high, the state stays active (state_o encoding: 0 active, 1 sleep, 2 deep sleep).
- R2: On entry, `deep_sleep_i` = 1 selects deep sleep (2) and 0 selects sleep (1). `clk_en_o` is low in both low states. `pwr_down_o` is high only in deep sleep.
- R3: A high `irq_pending_i` in either low state returns the block to active on the next clock edge, whichever request started the sleep.
- R4: A high `debug_req_i` in either low state returns the block to active on the next clock edge.
- R5: A high `event_i` wakes the block from a sleep (state 1) that the wait-for-event strobe started.
- R6: `event_i` does not wake the block from a sleep started by wait-for-interrupt or by sleep-on-exit. It does not wake the block from deep sleep either. If both strobes come together, wait-for-interrupt wins.
- R7: `thread_return_i` with `sleep_on_exit_i` = 1 and no pending interrupt starts a sleep. With `sleep_on_exit_i` = 0, the block stays active.
- R8: An event that cannot wake the block sets the event latch. A later wait-for-event clears the latch and leaves the block active. The wait-for-event after that sleeps normally.
- R9: `wake_o` is high for exactly one cycle after each wakeup. It is the same cycle in which `clk_en_o` returns high, and it is never high in any other cycle.
- R10: After reset the block is active, with `clk_en_o` = 1, `pwr_down_o` = 0, `wake_o` = 0 and the event latch clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wfi_i | input | 1 | Wait-for-interrupt strobe |
| wfe_i | input | 1 | Wait-for-event strobe |
| irq_pending_i | input | 1 | An enabled interrupt is pending (retained in deep sleep) |
| event_i | input | 1 | External event input |
| debug_req_i | input | 1 | Debug wakeup request |
| thread_return_i | input | 1 | Last handler is returning to thread code |
| sleep_on_exit_i | input | 1 | Sleep instead of returning to thread code |
| deep_sleep_i | input | 1 | Select deep sleep on entry |
| state_o | output | 2 | 0 active, 1 sleep, 2 deep sleep |
| clk_en_o | output | 1 | Core clock-gate enable |
| pwr_down_o | output | 1 | Power-down request |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench sends an event into a wait-for-interrupt sleep and into a deep sleep. A design that woke on that event would come back to active too early. It also checks that the ignored event left the latch set: the next wait-for-event must not sleep, and the one after it must. A design that dropped the latch, or never cleared it, fails one of those two steps. A strobe that arrives with an interrupt already pending must leave the block active. A controller that slept anyway would lose that interrupt's wakeup. Each wakeup checks that `wake_o` lines up with `clk_en_o` and falls one cycle later. A stretched or early pulse shows up there.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    PWR_ACTIVE = 2'd0,
    PWR_SLEEP  = 2'd1,
    PWR_DEEP   = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pwr_evt_latch.sv
module pwr_evt_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect
  import pwr_sleep_pkg::*;
(
  input  pwr_state_e state_i,
  input  logic       wfe_mode_i,
  input  logic       irq_pending_i,
  input  logic       debug_req_i,
  input  logic       event_i,
  output logic       wake_o,
  output logic       evt_wake_o
);
  // deep sleep: always-on logic sees only retained pending and debug
  always_comb begin
    evt_wake_o = (state_i == PWR_SLEEP) && wfe_mode_i && event_i;
    unique case (state_i)
      PWR_SLEEP: wake_o = irq_pending_i || debug_req_i || evt_wake_o;
      PWR_DEEP:  wake_o = irq_pending_i || debug_req_i;
      default:   wake_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_sleep_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_i,
  input  logic       enter_wfe_i,
  input  logic       deep_sleep_i,
  input  logic       wake_i,
  output pwr_state_e state_o,
  output logic       wfe_mode_o,
  output logic       wake_pulse_o
);
  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == PWR_ACTIVE) begin
      if (enter_i) state_d = deep_sleep_i ? PWR_DEEP : PWR_SLEEP;
    end else if (wake_i) begin
      state_d = PWR_ACTIVE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= PWR_ACTIVE;
      wfe_mode_o   <= 1'b0;
      wake_pulse_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      wake_pulse_o <= (state_q != PWR_ACTIVE) && wake_i;
      if (state_q == PWR_ACTIVE && enter_i) wfe_mode_o <= enter_wfe_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wfi_i,
  input  logic               wfe_i,
  input  logic               irq_pending_i,
  input  logic               event_i,
  input  logic               debug_req_i,
  input  logic               thread_return_i,
  input  logic               sleep_on_exit_i,
  input  logic               deep_sleep_i,
  output logic [STATE_W-1:0] state_o,
  output logic               clk_en_o,
  output logic               pwr_down_o,
  output logic               wake_o
);
  pwr_state_e state;
  logic wfe_mode, wake_det, evt_wake, evt_q;
  logic is_active, wfe_only, evt_avail, enter_req;

  assign is_active = (state == PWR_ACTIVE);
  assign wfe_only  = wfe_i && !wfi_i;
  assign evt_avail = evt_q || event_i;
  assign enter_req = !irq_pending_i &&
                     (wfi_i || (wfe_only && !evt_avail) ||
                      (thread_return_i && sleep_on_exit_i));

  pwr_evt_latch u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (event_i && !evt_wake),
    .clr_i  (is_active && wfe_only),
    .q_o    (evt_q)
  );

  pwr_wake_detect u_wake (
    .state_i       (state),
    .wfe_mode_i    (wfe_mode),
    .irq_pending_i (irq_pending_i),
    .debug_req_i   (debug_req_i),
    .event_i       (event_i),
    .wake_o        (wake_det),
    .evt_wake_o    (evt_wake)
  );

  pwr_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_i      (enter_req),
    .enter_wfe_i  (wfe_only),
    .deep_sleep_i (deep_sleep_i),
    .wake_i       (wake_det),
    .state_o      (state),
    .wfe_mode_o   (wfe_mode),
    .wake_pulse_o (wake_o)
  );

  assign state_o    = state;
  assign clk_en_o   = is_active;
  assign pwr_down_o = (state == PWR_DEEP);
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk
  import pwr_sleep_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wfi_i,
  input logic               wfe_i,
  input logic               irq_pending_i,
  input logic               event_i,
  input logic               debug_req_i,
  input logic [STATE_W-1:0] state_o,
  input logic               clk_en_o,
  input logic               pwr_down_o,
  input logic               wake_o
);
  localparam logic [STATE_W-1:0] ST_ACT  = 2'd0;
  localparam logic [STATE_W-1:0] ST_DEEP = 2'd2;

  assert_pending_blocks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ACT && (wfi_i || wfe_i) && irq_pending_i) |=> state_o == ST_ACT);

  assert_deep_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> !clk_en_o);

  assert_irq_wakes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_ACT && irq_pending_i) |=> (clk_en_o && wake_o));

  assert_debug_wakes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_ACT && debug_req_i) |=> clk_en_o);

  assert_deep_ignores_event_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_DEEP && !irq_pending_i && !debug_req_i) |=> state_o == ST_DEEP);

  assert_wake_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  assert_wake_with_clk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> clk_en_o);

  assert_clk_rise_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_en_o) |-> wake_o);
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wfi_i         (wfi_i),
  .wfe_i         (wfe_i),
  .irq_pending_i (irq_pending_i),
  .event_i       (event_i),
  .debug_req_i   (debug_req_i),
  .state_o       (state_o),
  .clk_en_o      (clk_en_o),
  .pwr_down_o    (pwr_down_o),
  .wake_o        (wake_o)
);

// File: tb/pwr_sleep_ctrl_tb_top.sv
module pwr_sleep_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 0, wfe = 0, irq = 0, evt = 0, dbg = 0, tret = 0, soe = 0, deep = 0;
  logic [1:0] state;
  logic clk_en, pwr_down, wake;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_sleep_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wfi_i(wfi), .wfe_i(wfe),
    .irq_pending_i(irq), .event_i(evt), .debug_req_i(dbg),
    .thread_return_i(tret), .sleep_on_exit_i(soe), .deep_sleep_i(deep),
    .state_o(state), .clk_en_o(clk_en), .pwr_down_o(pwr_down), .wake_o(wake)
  );

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one cycle with the given strobes, then released; sample at negedge
  task automatic cyc(bit a_wfi, bit a_wfe, bit a_irq, bit a_evt, bit a_dbg, bit a_tret);
    wfi = a_wfi; wfe = a_wfe; irq = a_irq; evt = a_evt; dbg = a_dbg; tret = a_tret;
    @(posedge clk); @(negedge clk);
    wfi = 0; wfe = 0; irq = 0; evt = 0; dbg = 0; tret = 0;
  endtask

  task automatic t_reset();
    chk("R10 state", state, 0);
    chk("R10 clk_en", clk_en, 1);
    chk("R10 pwr_down", pwr_down, 0);
    chk("R10 wake", wake, 0);
    cyc(0, 1, 0, 0, 0, 0);          // latch clear -> wfe sleeps
    chk("R10 latch clear", state, 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R10 back active", state, 0);
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pending_blocks();
    cyc(1, 0, 1, 0, 0, 0);
    chk("R1 wfi pending", state, 0);
    cyc(0, 1, 1, 0, 0, 0);
    chk("R1 wfe pending", state, 0);
    chk("R1 no wake", wake, 0);
  endtask

  task automatic t_wfi_event_latch();
    cyc(1, 0, 0, 0, 0, 0);
    chk("R1 wfi sleep", state, 1);
    chk("R2 light clk_en", clk_en, 0);
    chk("R2 light pwr_down", pwr_down, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 event ignored wfi", state, 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R3 irq wake", state, 0);
    chk("R9 wake pulse", wake, 1);
    chk("R9 clk_en with pulse", clk_en, 1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R9 pulse one cycle", wake, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R8 latched wfe returns", state, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R8 latch consumed", state, 1);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R5 event wakes wfe", state, 0);
    chk("R5 wake pulse", wake, 1);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R8 wake event not latched", state, 1);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R4 debug wakes light", state, 0);
  endtask

  task automatic t_active_event();
    cyc(0, 0, 0, 1, 0, 0);
    chk("R8 active event", state, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);
    chk("R8 wfe returns", state, 0);
    chk("R8 no pulse", wake, 0);
    cyc(1, 1, 0, 0, 0, 0);
    chk("R6 both strobes sleep", state, 1);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 wfi wins event ignored", state, 1);
    cyc(0, 0, 1, 0, 0, 0);
    cyc(0, 1, 0, 0, 0, 0);          // consume event latched above
    chk("R8 relatched", state, 0);
  endtask

  task automatic t_deep();
    deep = 1;
    cyc(0, 1, 0, 0, 0, 0);
    chk("R2 deep state", state, 2);
    chk("R2 deep pwr_down", pwr_down, 1);
    chk("R2 deep clk_en", clk_en, 0);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 deep ignores event", state, 2);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R4 debug wakes deep", state, 0);
    chk("R9 deep wake pulse", wake, 1);
    cyc(0, 1, 0, 0, 0, 0);          // latched event from deep
    chk("R8 deep event latched", state, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R2 deep via wfi", state, 2);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R3 irq wakes deep", state, 0);
    deep = 0;
  endtask

  task automatic t_sleep_on_exit();
    soe = 0;
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 bit clear stays", state, 0);
    soe = 1;
    cyc(0, 0, 1, 0, 0, 1);
    chk("R7 pending stays", state, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 exit sleeps", state, 1);
    cyc(0, 0, 0, 1, 0, 0);
    chk("R6 event ignored exit", state, 1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R3 irq wakes exit", state, 0);
    soe = 0;
    cyc(0, 1, 0, 0, 0, 0);          // clear latch
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pending_blocks();
    t_wfi_event_latch();
    t_active_event();
    t_deep();
    t_sleep_on_exit();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule